// File: doc/BRIEF.md
# Control Endpoint Handshake Responder

This block keeps the state of one USB device control endpoint and chooses the bus handshake for every token that the packet decoder hands it. The endpoint state has three bits: armed (software has set up a data or status stage), halted (software has asked for a protocol stall) and setup-pending (a SETUP was received and software has not yet dealt with it). Each token gets one registered response code, one clock after the decoder strobes it. The block also raises a system-error pulse when a SETUP meets an overflowing receive FIFO.

SETUP always takes precedence. It is acknowledged in every endpoint state. It disarms the endpoint, so buffers armed for an earlier data or status stage are never used. It also releases a halt and marks setup-pending. While setup-pending is set, software cannot arm the endpoint, and data tokens are refused. A zero-length status stage is armed in the same way as a data stage. A transmit FIFO that runs dry during an IN is signalled on the bus as a deliberately forced bit-stuff error.

Top module: `ctl_ep_responder`

## Requirements
- R1: After reset, `armed`, `halted`, `setup_pend`, `hs_valid` and `sys_err` are all 0, and `hs_code` is 0.
- R2: `hs_valid` is 1 in exactly the cycles that follow a cycle with `tok_valid` high. `hs_code` and `sys_err` are registered at that same edge. Codes: 0 none, 1 ACK, 2 NAK, 3 NYET, 4 STALL, 5 transmit, 6 forced bit-stuff error.
- R3: A SETUP (`tok_kind`=0) without `rx_ovf` is answered with code 1 in every endpoint state. After that edge, `setup_pend`=1, `armed`=0 and `halted`=0.
- R4: A SETUP with `rx_ovf` high gives code 0 and `sys_err`=1. It changes no state bit.
- R5: IN (1), OUT (2) and PING (3) tokens get code 4 while `halted`=1, whatever the other state bits are.
- R6: When not halted, IN, OUT and PING get code 2 if `setup_pend`=1 or `armed`=0.
- R7: An IN on an armed endpoint that is not halted and has no setup pending gives code 5, or code 6 if `tx_unf` is high.
- R8: An OUT in that same armed state gives code 2 if `rx_ovf` is high. Otherwise it gives code 1 when `more_pkts`=1 and code 3 when `more_pkts`=0.
- R9: A PING in that same armed state gives code 1.
- R10: Token kinds 4 to 7 give code 0 with `sys_err`=0. They change no state bit.
- R11: `arm_req` sets `armed` at the next edge, but not while `setup_pend`=1 and not in a cycle where a SETUP is accepted. `pend_clr` clears `setup_pend`, except when a SETUP is accepted in the same cycle.
- R12: `halt_set` sets `halted` and `halt_clr` clears it. If both are high, the set wins. An accepted SETUP clears `halted` even when `halt_set` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tok_valid | input | 1 | Token strobe from the packet decoder |
| tok_kind | input | 3 | Token kind: 0 SETUP, 1 IN, 2 OUT, 3 PING, 4-7 invalid |
| tx_unf | input | 1 | Transmit latency FIFO underflow |
| rx_ovf | input | 1 | Receive latency FIFO overflow |
| more_pkts | input | 1 | Transfer descriptor still has packets remaining |
| arm_req | input | 1 | Software request to arm the endpoint |
| halt_set | input | 1 | Software request to halt the endpoint |
| halt_clr | input | 1 | Software request to release a halt |
| pend_clr | input | 1 | Software acknowledge of a received SETUP |
| hs_valid | output | 1 | Response strobe |
| hs_code | output | 3 | Response code |
| sys_err | output | 1 | System-error pulse |
| armed | output | 1 | Endpoint armed bit |
| halted | output | 1 | Endpoint halted bit |
| setup_pend | output | 1 | Setup-received bit |

## Verification
Two things can land in the same cycle: an accepted SETUP and a software write (arm, halt set, or pending clear). The SETUP must win in every case. Directed cycles line up each such pair on one edge. Random traffic also drives software strobes alongside tokens of every kind. After each edge, a bench model compares the three state bits with the expected outcome, so an arm that survives a SETUP, or a halt that does, shows up at once.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;

  localparam int KIND_W = 3;
  localparam int CODE_W = 3;

  localparam logic [KIND_W-1:0] TK_SETUP = 3'd0;
  localparam logic [KIND_W-1:0] TK_IN    = 3'd1;
  localparam logic [KIND_W-1:0] TK_OUT   = 3'd2;
  localparam logic [KIND_W-1:0] TK_PING  = 3'd3;

  typedef enum logic [CODE_W-1:0] {
    HS_NONE  = 3'd0,
    HS_ACK   = 3'd1,
    HS_NAK   = 3'd2,
    HS_NYET  = 3'd3,
    HS_STALL = 3'd4,
    HS_TX    = 3'd5,
    HS_BSERR = 3'd6
  } hs_e;

  typedef struct packed {
    logic armed;
    logic halted;
    logic pend;
  } ep_state_t;

  typedef struct packed {
    hs_e  code;
    logic syserr;
  } resp_t;

  // Response for a data token (IN/OUT/PING) once the endpoint is known to
  // be armed, not halted and not locked out.
  function automatic hs_e data_resp(input logic [KIND_W-1:0] kind,
                                    input logic unf, input logic ovf,
                                    input logic more);
    hs_e r;
    case (kind)
      TK_IN:   r = unf ? HS_BSERR : HS_TX;
      TK_OUT:  r = ovf ? HS_NAK : (more ? HS_ACK : HS_NYET);
      TK_PING: r = HS_ACK;
      default: r = HS_NONE;
    endcase
    return r;
  endfunction

  // Full response selection; SETUP overrides, then halt, then lockout/unarmed.
  function automatic resp_t choose_resp(input logic [KIND_W-1:0] kind,
                                        input ep_state_t st,
                                        input logic unf, input logic ovf,
                                        input logic more);
    resp_t r;
    r.code   = HS_NONE;
    r.syserr = 1'b0;
    if (kind == TK_SETUP) begin
      if (ovf) r.syserr = 1'b1;
      else     r.code   = HS_ACK;
    end else if (kind == TK_IN || kind == TK_OUT || kind == TK_PING) begin
      if (st.halted)                r.code = HS_STALL;
      else if (st.pend || !st.armed) r.code = HS_NAK;
      else                          r.code = data_resp(kind, unf, ovf, more);
    end
    return r;
  endfunction

endpackage

// File: rtl/ctl_ep_decide.sv
module ctl_ep_decide
  import ctl_ep_pkg::*;
(
  input  logic              tok_valid,
  input  logic [KIND_W-1:0] tok_kind,
  input  ep_state_t         st,
  input  logic              tx_unf,
  input  logic              rx_ovf,
  input  logic              more_pkts,
  output resp_t             resp,
  output logic              setup_take
);
  always_comb begin
    resp       = choose_resp(tok_kind, st, tx_unf, rx_ovf, more_pkts);
    setup_take = tok_valid && (tok_kind == TK_SETUP) && !rx_ovf;
  end
endmodule

// File: rtl/ctl_ep_state.sv
module ctl_ep_state
  import ctl_ep_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      setup_take,
  input  logic      arm_req,
  input  logic      halt_set,
  input  logic      halt_clr,
  input  logic      pend_clr,
  output ep_state_t st,
  output logic      arm_grant
);
  ep_state_t nxt;

  always_comb begin
    arm_grant = arm_req && !st.pend && !setup_take;
    nxt       = st;
    if (setup_take) begin
      nxt.armed  = 1'b0;
      nxt.halted = 1'b0;
      nxt.pend   = 1'b1;
    end else begin
      if (arm_grant)     nxt.armed  = 1'b1;
      if (halt_set)      nxt.halted = 1'b1;
      else if (halt_clr) nxt.halted = 1'b0;
      if (pend_clr)      nxt.pend   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= nxt;
  end
endmodule

// File: rtl/ctl_ep_hs_reg.sv
module ctl_ep_hs_reg
  import ctl_ep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_valid,
  input  resp_t             resp,
  output logic              hs_valid,
  output logic [CODE_W-1:0] hs_code,
  output logic              sys_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_valid <= 1'b0;
      hs_code  <= HS_NONE;
      sys_err  <= 1'b0;
    end else begin
      hs_valid <= tok_valid;
      hs_code  <= tok_valid ? resp.code : HS_NONE;
      sys_err  <= tok_valid && resp.syserr;
    end
  end
endmodule

// File: rtl/ctl_ep_responder.sv
module ctl_ep_responder
  import ctl_ep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_valid,
  input  logic [KIND_W-1:0] tok_kind,
  input  logic              tx_unf,
  input  logic              rx_ovf,
  input  logic              more_pkts,
  input  logic              arm_req,
  input  logic              halt_set,
  input  logic              halt_clr,
  input  logic              pend_clr,
  output logic              hs_valid,
  output logic [CODE_W-1:0] hs_code,
  output logic              sys_err,
  output logic              armed,
  output logic              halted,
  output logic              setup_pend
);
  ep_state_t st;
  resp_t     resp;
  logic      setup_take;
  logic      arm_grant;

  ctl_ep_decide u_decide (
    .tok_valid (tok_valid),
    .tok_kind  (tok_kind),
    .st        (st),
    .tx_unf    (tx_unf),
    .rx_ovf    (rx_ovf),
    .more_pkts (more_pkts),
    .resp      (resp),
    .setup_take(setup_take)
  );

  ctl_ep_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .setup_take(setup_take),
    .arm_req   (arm_req),
    .halt_set  (halt_set),
    .halt_clr  (halt_clr),
    .pend_clr  (pend_clr),
    .st        (st),
    .arm_grant (arm_grant)
  );

  ctl_ep_hs_reg u_hs (
    .clk      (clk),
    .rst_n    (rst_n),
    .tok_valid(tok_valid),
    .resp     (resp),
    .hs_valid (hs_valid),
    .hs_code  (hs_code),
    .sys_err  (sys_err)
  );

  assign armed      = st.armed;
  assign halted     = st.halted;
  assign setup_pend = st.pend;
endmodule

// File: rtl/ctl_ep_chk.sv
module ctl_ep_chk
  import ctl_ep_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tok_valid,
  input logic [KIND_W-1:0] tok_kind,
  input logic              rx_ovf,
  input logic              arm_req,
  input logic              halt_set,
  input logic              halt_clr,
  input logic              pend_clr,
  input logic              setup_take,
  input logic              hs_valid,
  input logic [CODE_W-1:0] hs_code,
  input logic              sys_err,
  input logic              armed,
  input logic              halted,
  input logic              setup_pend
);
  assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid |=> hs_valid);

  assert_no_spurious_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_valid |=> !hs_valid && !sys_err);

  assert_setup_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    setup_take |=> hs_code == HS_ACK && setup_pend && !armed && !halted);

  assert_setup_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && tok_kind == TK_SETUP && rx_ovf |=> sys_err && hs_code == HS_NONE);

  assert_halt_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && halted && (tok_kind == TK_IN || tok_kind == TK_OUT || tok_kind == TK_PING)
    |=> hs_code == HS_STALL);

  assert_invalid_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && tok_kind > TK_PING && !arm_req && !halt_set && !halt_clr && !pend_clr
    |=> hs_code == HS_NONE && !sys_err && $stable(armed) && $stable(halted) && $stable(setup_pend));

  assert_syserr_with_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sys_err |-> hs_valid);
endmodule

bind ctl_ep_responder ctl_ep_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tok_valid (tok_valid),
  .tok_kind  (tok_kind),
  .rx_ovf    (rx_ovf),
  .arm_req   (arm_req),
  .halt_set  (halt_set),
  .halt_clr  (halt_clr),
  .pend_clr  (pend_clr),
  .setup_take(setup_take),
  .hs_valid  (hs_valid),
  .hs_code   (hs_code),
  .sys_err   (sys_err),
  .armed     (armed),
  .halted    (halted),
  .setup_pend(setup_pend)
);

// File: tb/test_ctl_ep_responder.sv
module test_ctl_ep_responder;
  localparam int PERIOD = 10;
  localparam int RAND_CYCLES = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tok_valid = 1'b0;
  logic [2:0] tok_kind = 3'd0;
  logic tx_unf = 1'b0, rx_ovf = 1'b0, more_pkts = 1'b0;
  logic arm_req = 1'b0, halt_set = 1'b0, halt_clr = 1'b0, pend_clr = 1'b0;
  logic hs_valid, sys_err, armed, halted, setup_pend;
  logic [2:0] hs_code;

  int n_chk = 0;
  int n_fail = 0;
  logic m_arm = 0, m_halt = 0, m_pend = 0;
  logic e_valid = 0, e_sys = 0;
  logic [2:0] e_code = 0;
  string e_tag = "R1";
  string s_tag_arm = "R1", s_tag_halt = "R1", s_tag_pend = "R1";

  always #(PERIOD/2) clk = ~clk;

  ctl_ep_responder i_ctl_ep_responder (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .tx_unf(tx_unf), .rx_ovf(rx_ovf), .more_pkts(more_pkts),
    .arm_req(arm_req), .halt_set(halt_set), .halt_clr(halt_clr), .pend_clr(pend_clr),
    .hs_valid(hs_valid), .hs_code(hs_code), .sys_err(sys_err),
    .armed(armed), .halted(halted), .setup_pend(setup_pend)
  );

  task automatic check(input logic ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Bench view of the response rules, keyed on the token kind first.
  function automatic logic [3:0] bench_code(input logic [2:0] k, input logic un,
                                            input logic ov, input logic pl,
                                            output string tag);
    logic [2:0] c; logic s;
    s = 0;
    case (k)
      3'd0: begin tag = ov ? "R4" : "R3"; c = ov ? 3'd0 : 3'd1; s = ov; end
      3'd1, 3'd2, 3'd3: begin
        if (m_halt) begin tag = "R5"; c = 3'd4; end
        else if (m_pend || !m_arm) begin tag = "R6"; c = 3'd2; end
        else if (k == 3'd1) begin tag = "R7"; c = un ? 3'd6 : 3'd5; end
        else if (k == 3'd2) begin tag = "R8"; c = ov ? 3'd2 : (pl ? 3'd1 : 3'd3); end
        else begin tag = "R9"; c = 3'd1; end
      end
      default: begin tag = "R10"; c = 3'd0; end
    endcase
    return {c, s};
  endfunction

  task automatic check_outputs();
    check(hs_valid == e_valid, (e_tag == "R1") ? "R1" : "R2", "hs_valid", hs_valid, e_valid);
    check(hs_code == e_code, e_tag, "hs_code", hs_code, e_code);
    check(sys_err == e_sys, e_valid ? e_tag : "R2", "sys_err", sys_err, e_sys);
    check(armed == m_arm, s_tag_arm, "armed", armed, m_arm);
    check(halted == m_halt, s_tag_halt, "halted", halted, m_halt);
    check(setup_pend == m_pend, s_tag_pend, "setup_pend", setup_pend, m_pend);
  endtask

  task automatic apply(input logic tv, input logic [2:0] k, input logic un, input logic ov,
                       input logic pl, input logic ar, input logic hs, input logic hc,
                       input logic pc);
    logic [3:0] cs; string tg; logic take;
    @(negedge clk);
    check_outputs();
    tok_valid = tv; tok_kind = k; tx_unf = un; rx_ovf = ov; more_pkts = pl;
    arm_req = ar; halt_set = hs; halt_clr = hc; pend_clr = pc;
    cs = bench_code(k, un, ov, pl, tg);
    e_valid = tv;
    e_code  = tv ? cs[3:1] : 3'd0;
    e_sys   = tv && cs[0];
    e_tag   = tv ? tg : "R2";
    take = tv && k == 3'd0 && !ov;
    s_tag_arm = take ? "R3" : "R11";
    s_tag_halt = take ? "R3" : "R12";
    s_tag_pend = take ? "R3" : "R11";
    if (take) begin
      m_arm = 0; m_halt = 0; m_pend = 1;
    end else begin
      if (ar && !m_pend) m_arm = 1;
      if (hs) m_halt = 1; else if (hc) m_halt = 0;
      if (pc) m_pend = 0;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values checked on the first apply
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R6: not armed -> NAK; R11 arm
    apply(1, 3'd1, 0, 0, 0, 1, 0, 0, 0);
    apply(1, 3'd3, 0, 0, 0, 0, 0, 0, 0);       // R9 ping armed
    apply(1, 3'd1, 1, 0, 0, 0, 0, 0, 0);       // R7 underflow
    apply(1, 3'd2, 0, 0, 1, 0, 0, 0, 0);       // R8 more packets
    apply(1, 3'd2, 0, 1, 0, 0, 0, 0, 0);       // R8 overflow
    // R3 SETUP with arm and halt set on the same edge: SETUP wins
    apply(1, 3'd0, 0, 0, 0, 1, 1, 0, 0);
    apply(0, 0, 0, 0, 0, 1, 0, 0, 0);          // R11 arm blocked while pending
    apply(1, 3'd2, 0, 0, 0, 0, 0, 0, 1);       // R6 lockout NAK, clear pending
    apply(1, 3'd0, 0, 0, 0, 0, 0, 0, 1);       // R11 SETUP beats pend_clr
    apply(0, 0, 0, 0, 0, 0, 1, 1, 1);          // R12 set beats clear
    apply(1, 3'd0, 0, 1, 0, 0, 0, 0, 0);       // R4 overflow syserr, state kept
    apply(1, 3'd5, 0, 0, 0, 0, 0, 0, 0);       // R10 invalid
    apply(1, 3'd0, 0, 0, 0, 0, 0, 0, 0);       // R3 ack while halted
    for (int i = 0; i < RAND_CYCLES; i++) begin
      logic [2:0] k;
      int w;
      w = $urandom % 10;
      k = (w < 2) ? 3'd0 : (w < 4) ? 3'd1 : (w < 6) ? 3'd2 : (w < 8) ? 3'd3 : 3'($urandom % 8);
      apply(($urandom % 4) != 0, k, ($urandom % 4) == 0, ($urandom % 4) == 0, $urandom % 2,
            ($urandom % 3) == 0, ($urandom % 10) == 0, ($urandom % 6) == 0,
            ($urandom % 4) == 0);
    end
    @(negedge clk);
    check_outputs();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule